// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a pulse-width modulation channel. A 16-bit counter steps once per prescaled tick and runs through a period whose length comes from a programmable period register. It reports its current value, a strobe when it lands on zero, a strobe when it lands on the period value, and the direction of its next step. Compare and output-action stages downstream use these outputs to form the waveform edges.

Software programs the block through a single-word write port. A control word sets the count mode, the run mode, the two prescaler fields and the period-load mode. The period value is written on the same port. In shadow mode a new period takes effect at the next zero crossing, so the period of a waveform never changes partway through a cycle. A clock-enable input stands in for gating of the time-base clock. While it is low, nothing in the time base advances.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, count_o is 0 and zero_o, period_o and dir_o are all 0. The counter is stopped, in up mode, with an active period of 0, immediate load off, and both prescaler fields at 0.
- R2: In up mode (control bits 1:0 = 00), each advance adds 1 to the count. An advance from a count at or above the active period goes to 0 instead. dir_o is 0.
- R3: In down mode (bits 1:0 = 01), each advance subtracts 1 from the count. An advance from 0, or from a count above the period, loads the active period. dir_o is 1.
- R4: In up-down mode (bits 1:0 = 10), the counter climbs to the period and then descends to 0. dir_o turns 1 in the cycle the count arrives at the period and turns 0 in the cycle it arrives at 0.
- R5: In freeze mode (bits 1:0 = 11), the count holds and neither strobe fires.
- R6: Run mode is set by control bits 15:14. The value 00 halts the counter from the next clock. The values 11 and 10 let it run freely.
- R7: Run mode 01 lets the counter advance until it arrives at 0 (up and up-down modes) or at the period (down mode). After that it holds. Any control write re-arms it.
- R8: The prescaler divides enabled clocks by (2 to the power of bits 12:10) times (1 if bits 9:7 are 0, otherwise twice bits 9:7). A control write restarts the prescaler, so the first advance comes that many enabled cycles after the write edge.
- R9: While clk_en is low, the count, the prescaler and the run state hold, and no strobe fires.
- R10: If control bit 3 is 1, a period write updates the active period at once. If bit 3 is 0, the write goes to a shadow copy, and that copy moves into the active period in the cycle the counter arrives at 0.
- R11: zero_o and period_o are high for one cycle, in the same cycle that count_o first shows the new value after an advance. zero_o marks an advance to 0. period_o marks an advance to the active period in force before that edge.
- R12: A write with wr_sel = 0 loads the control word. A write with wr_sel = 1 loads the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Time-base clock enable (models gating) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data | input | 16 | Write data |
| count_o | output | CNT_W | Counter value |
| zero_o | output | 1 | Pulse on an advance to zero |
| period_o | output | 1 | Pulse on an advance to the period |
| dir_o | output | 1 | Direction of the next step (1 = down) |

## Verification
A register write takes effect at the edge that captures it, and the counter reacts to it from the following edge. A control write restarts the prescaler, so with a prescale of N the first advance lands on the Nth edge after the write edge. The count, the strobes and the direction all update on the same edge as the advance. The bench drives inputs and samples outputs on falling edges only. A cycle-level reference model, updated on the same rising edges as the design, is compared against every output on every cycle. The directed checks count edges from the write edge, using the latencies above.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    // control word layout; the field positions are decoded by the time base
    localparam int CW_W      = 16;
    localparam int FLD_W     = 3;
    localparam int MODE_LSB  = 0;
    localparam int LDIMM_BIT = 3;
    localparam int HSP_LSB   = 7;
    localparam int CKD_LSB   = 10;
    localparam int RUN_LSB   = 14;

    localparam int FLD_MAX   = (1 << FLD_W) - 1;
    localparam int PSC_MAX   = (1 << FLD_MAX) * (2 * FLD_MAX);
    localparam int PSC_W     = $clog2(PSC_MAX + 1);

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RM_STOP     = 2'b00,
        RM_ONCE     = 2'b01,
        RM_FREE_ALT = 2'b10,
        RM_FREE     = 2'b11
    } run_mode_e;
endpackage

// File: rtl/pwm_tb_regs.sv
module pwm_tb_regs
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CW_W-1:0]  wr_data,
    input  logic             load_zero,
    output run_mode_e        run,
    output cnt_mode_e        mode,
    output logic [FLD_W-1:0] ckd,
    output logic [FLD_W-1:0] hsp,
    output logic [CNT_W-1:0] prd,
    output logic             ctrl_wr
);
    typedef struct packed {
        run_mode_e        run;
        cnt_mode_e        mode;
        logic             ld_imm;
        logic [FLD_W-1:0] ckd;
        logic [FLD_W-1:0] hsp;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } regs_t;

    regs_t r_d, r_q;
    logic  prd_wr;

    always_comb begin
        ctrl_wr = wr_en & ~wr_sel;
        prd_wr  = wr_en & wr_sel;
        r_d     = r_q;
        if (ctrl_wr) begin
            r_d.run    = run_mode_e'(wr_data[RUN_LSB +: 2]);
            r_d.mode   = cnt_mode_e'(wr_data[MODE_LSB +: 2]);
            r_d.ld_imm = wr_data[LDIMM_BIT];
            r_d.ckd    = wr_data[CKD_LSB +: FLD_W];
            r_d.hsp    = wr_data[HSP_LSB +: FLD_W];
        end
        // shadow transfer at the zero arrival
        if (load_zero && !r_q.ld_imm) begin
            r_d.active = r_q.shadow;
        end
        if (prd_wr) begin
            r_d.shadow = wr_data[CNT_W-1:0];
            if (r_q.ld_imm) begin
                r_d.active = wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{run: RM_STOP, mode: CM_UP, ld_imm: 1'b0, ckd: '0,
                     hsp: '0, shadow: '0, active: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign run  = r_q.run;
    assign mode = r_q.mode;
    assign ckd  = r_q.ckd;
    assign hsp  = r_q.hsp;
    assign prd  = r_q.active;
endmodule

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale
    import pwm_tb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             restart,
    input  logic [FLD_W-1:0] ckd,
    input  logic [FLD_W-1:0] hsp,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_t;

    psc_t             p_d, p_q;
    logic [PSC_W-1:0] hs_fac;
    logic [PSC_W-1:0] div_m1;

    always_comb begin
        // linear stage: 1 or twice the field; binary stage: power of two
        hs_fac = (hsp == '0) ? PSC_W'(1) : PSC_W'({hsp, 1'b0});
        div_m1 = (hs_fac << ckd) - PSC_W'(1);
        tick   = clk_en & (p_q.cnt >= div_m1);
        p_d    = p_q;
        if (restart || tick) begin
            p_d.cnt = '0;
        end else if (clk_en) begin
            p_d.cnt = p_q.cnt + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  run_mode_e        run,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd,
    input  logic             ctrl_wr,
    output logic [CNT_W-1:0] count,
    output logic             zero_hit,
    output logic             prd_hit,
    output logic             dir_dn,
    output logic             done,
    output logic             load_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             done;
        logic             zero;
        logic             pm;
    } ctr_t;

    ctr_t             s_d, s_q;
    logic             go, adv, hit, ndir;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        go   = (run == RM_FREE) || (run == RM_FREE_ALT) ||
               ((run == RM_ONCE) && !s_q.done);
        adv  = tick && go && (mode != CM_HOLD);
        nxt  = s_q.cnt;
        ndir = s_q.dir;
        case (mode)
            CM_UP: begin
                ndir = 1'b0;
                nxt  = (s_q.cnt >= prd) ? '0 : s_q.cnt + ONE;
            end
            CM_DOWN: begin
                ndir = 1'b1;
                nxt  = (s_q.cnt == '0 || s_q.cnt > prd) ? prd : s_q.cnt - ONE;
            end
            CM_UPDN: begin
                if (!s_q.dir) begin
                    if (s_q.cnt < prd) begin
                        nxt  = s_q.cnt + ONE;
                        ndir = (nxt == prd);
                    end else if (s_q.cnt != '0) begin
                        nxt  = s_q.cnt - ONE;
                        ndir = (nxt != '0);
                    end else begin
                        nxt  = '0;
                        ndir = 1'b0;
                    end
                end else begin
                    if (s_q.cnt != '0) begin
                        nxt  = s_q.cnt - ONE;
                        ndir = (nxt != '0);
                    end else if (prd != '0) begin
                        nxt  = ONE;
                        ndir = (nxt == prd);
                    end else begin
                        nxt  = '0;
                        ndir = 1'b0;
                    end
                end
            end
            default: begin
                nxt  = s_q.cnt;
                ndir = s_q.dir;
            end
        endcase

        hit       = (mode == CM_DOWN) ? (nxt == prd) : (nxt == '0);
        load_zero = adv && (nxt == '0);

        s_d      = s_q;
        s_d.zero = adv && (nxt == '0);
        s_d.pm   = adv && (nxt == prd);
        if (adv) begin
            s_d.cnt = nxt;
        end
        if (mode == CM_UP || mode == CM_DOWN || adv) begin
            s_d.dir = ndir;
        end
        if (ctrl_wr) begin
            s_d.done = 1'b0;
        end else if (adv && run == RM_ONCE && hit) begin
            s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count    = s_q.cnt;
    assign zero_hit = s_q.zero;
    assign prd_hit  = s_q.pm;
    assign dir_dn   = s_q.dir;
    assign done     = s_q.done;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [15:0]      wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o,
    output logic             period_o,
    output logic             dir_o
);
    run_mode_e        run;
    cnt_mode_e        mode;
    logic [FLD_W-1:0] ckd, hsp;
    logic [CNT_W-1:0] prd;
    logic             ctrl_wr, tick, load_zero, cnt_done;
    logic [1:0]       ctrl_run, ctrl_mode;

    pwm_tb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .load_zero (load_zero),
        .run       (run),
        .mode      (mode),
        .ckd       (ckd),
        .hsp       (hsp),
        .prd       (prd),
        .ctrl_wr   (ctrl_wr)
    );

    pwm_tb_prescale u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .restart (ctrl_wr),
        .ckd     (ckd),
        .hsp     (hsp),
        .tick    (tick)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .mode      (mode),
        .prd       (prd),
        .ctrl_wr   (ctrl_wr),
        .count     (count_o),
        .zero_hit  (zero_o),
        .prd_hit   (period_o),
        .dir_dn    (dir_o),
        .done      (cnt_done),
        .load_zero (load_zero)
    );

    assign ctrl_run  = run;
    assign ctrl_mode = mode;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic [CNT_W-1:0] count_o,
    input logic             zero_o,
    input logic             period_o,
    input logic             dir_o,
    input logic [1:0]       ctrl_run,
    input logic [1:0]       ctrl_mode,
    input logic             cnt_done
);
    a_r11_zero_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (count_o == '0));

    a_r9_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(count_o) && !zero_o && !period_o));

    a_r5_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode == 2'b11) |=> ($stable(count_o) && !zero_o && !period_o));

    a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run == 2'b00) |=> $stable(count_o));

    a_r7_once_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_done && ctrl_run == 2'b01) |=> $stable(count_o));

    a_r2_up_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode == 2'b00) |=> !dir_o);

    a_r3_down_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode == 2'b01) |=> dir_o);
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .count_o   (count_o),
    .zero_o    (zero_o),
    .period_o  (period_o),
    .dir_o     (dir_o),
    .ctrl_run  (ctrl_run),
    .ctrl_mode (ctrl_mode),
    .cnt_done  (cnt_done)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [W-1:0]  count_o;
    logic          zero_o, period_o, dir_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    bit model_chk = 0;

    always #4 clk = ~clk;

    pwm_timebase #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o),
        .zero_o(zero_o), .period_o(period_o), .dir_o(dir_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [1:0]  m_run, m_mode;
    logic        m_imm, m_dir, m_done, m_zero, m_pm;
    logic [2:0]  m_ckd, m_hsp;
    logic [15:0] m_shd, m_act, m_cnt;
    int          m_psc;

    function automatic int m_div(input logic [2:0] ck, input logic [2:0] hs);
        return (1 << ck) * ((hs == 0) ? 1 : 2 * hs);
    endfunction

    function automatic logic [16:0] m_next(input logic [15:0] c, input logic d,
                                           input logic [1:0] md, input logic [15:0] p);
        logic [15:0] n;
        logic        nd;
        n = c; nd = d;
        if (md == 2'b00) begin nd = 0; n = (c >= p) ? 16'd0 : c + 16'd1; end
        else if (md == 2'b01) begin nd = 1; n = (c == 0 || c > p) ? p : c - 16'd1; end
        else if (md == 2'b10) begin
            if (!d) begin
                if (c < p) begin n = c + 16'd1; nd = (n == p); end
                else if (c != 0) begin n = c - 16'd1; nd = (n != 0); end
                else begin n = 0; nd = 0; end
            end else begin
                if (c != 0) begin n = c - 16'd1; nd = (n != 0); end
                else if (p != 0) begin n = 16'd1; nd = (n == p); end
                else begin n = 0; nd = 0; end
            end
        end
        return {nd, n};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_imm = 0; m_ckd = 0; m_hsp = 0;
            m_shd = 0; m_act = 0; m_cnt = 0; m_dir = 0; m_done = 0;
            m_zero = 0; m_pm = 0; m_psc = 0;
        end else begin
            logic        tick, go, adv, cw, nd, hit;
            logic [15:0] n;
            logic [16:0] r;
            cw   = wr_en && !wr_sel;
            tick = clk_en && (m_psc >= m_div(m_ckd, m_hsp) - 1);
            go   = m_run[1] || (m_run == 2'b01 && !m_done);
            adv  = tick && go && (m_mode != 2'b11);
            r    = m_next(m_cnt, m_dir, m_mode, m_act);
            n    = r[15:0];
            nd   = r[16];
            hit  = (m_mode == 2'b01) ? (n == m_act) : (n == 0);
            m_zero = adv && (n == 0);
            m_pm   = adv && (n == m_act);
            if (cw) m_done = 0; else if (adv && m_run == 2'b01 && hit) m_done = 1;
            if (m_mode == 2'b00 || m_mode == 2'b01 || adv) m_dir = nd;
            if (adv && n == 0 && !m_imm) m_act = m_shd;
            if (adv) m_cnt = n;
            if (cw || tick) m_psc = 0; else if (clk_en) m_psc = m_psc + 1;
            if (wr_en && wr_sel) begin
                m_shd = wr_data;
                if (m_imm) m_act = wr_data;
            end
            if (cw) begin
                m_run = wr_data[15:14]; m_mode = wr_data[1:0]; m_imm = wr_data[3];
                m_ckd = wr_data[12:10]; m_hsp = wr_data[9:7];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_chk && !finished) begin
            string t;
            case (m_mode)
                2'b00: t = "R2 model count up";
                2'b01: t = "R3 model count down";
                2'b10: t = "R4 model count up-down";
                default: t = "R5 model count frozen";
            endcase
            chk(t, count_o, m_cnt);
            chk("R11 model zero strobe", zero_o, m_zero);
            chk("R11 model period strobe", period_o, m_pm);
            chk("R4 model direction", dir_o, m_dir);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_zero();
        int k = 0;
        do begin @(negedge clk); k++; end while (!zero_o && k < 200);
        chk("R11 zero strobe seen", zero_o, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #1_200_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int c0;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1;
        step(1);
        chk("R1 reset count", count_o, 0);
        chk("R1 reset zero", zero_o, 0);
        chk("R1 reset period", period_o, 0);
        chk("R1 reset dir", dir_o, 0);
        step(3);
        chk("R1 stopped after reset", count_o, 0);
        model_chk = 1;

        // prescale 2*2 = 4
        wr(0, 16'h0008);
        wr(1, 16'd100);
        wr(0, 16'hC000 | (1 << 10) | (1 << 7) | 16'h0008);
        step(3);
        chk("R8 no advance before 4th tick", count_o, 0);
        step(1);
        chk("R8 first advance at 4", count_o, 1);
        step(4);
        chk("R8 second advance at 8", count_o, 2);

        // prescale 4*6 = 24
        wr(0, 16'hC000 | (2 << 10) | (3 << 7) | 16'h0008);
        c0 = count_o;
        step(23);
        chk("R8 hold for 23 cycles", count_o, c0);
        step(1);
        chk("R8 advance at 24", count_o, c0 + 1);

        // stop immediately
        wr(0, 16'h0008);
        c0 = count_o;
        step(10);
        chk("R6 stop holds", count_o, c0);

        // one-shot up then down
        wr(1, 16'd5);
        wr(0, 16'h4008);
        step(20);
        chk("R7 once up halts at zero", count_o, 0);
        step(5);
        chk("R7 once up stays", count_o, 0);
        wr(0, 16'h4009);
        step(20);
        chk("R7 once down halts at period", count_o, 5);

        // clock enable low
        wr(0, 16'hC008);
        step(2);
        clk_en = 0;
        c0 = count_o;
        step(10);
        chk("R9 gated hold", count_o, c0);
        chk("R9 no strobe", zero_o, 0);
        clk_en = 1;

        // shadow load at zero
        wr(0, 16'hC000);
        wr(1, 16'd9);
        wait_zero();
        step(9);
        chk("R10 R12 shadow period in force", count_o, 9);
        chk("R11 period strobe", period_o, 1);
        step(1);
        chk("R2 wrap to zero", count_o, 0);
        chk("R11 zero strobe on wrap", zero_o, 1);
        chk("R11 period strobe one cycle", period_o, 0);

        // freeze
        wr(0, 16'hC003);
        c0 = count_o;
        step(10);
        chk("R5 freeze holds", count_o, c0);
        chk("R5 no strobe", zero_o, 0);

        // up-down
        wr(0, 16'hC00A);
        wr(1, 16'd3);
        wait_zero();
        chk("R4 dir up at zero", dir_o, 0);
        step(3);
        chk("R4 reaches period", count_o, 3);
        chk("R4 dir down at period", dir_o, 1);
        step(2);
        chk("R4 descending", count_o, 1);
        step(1);
        chk("R4 back at zero", count_o, 0);
        chk("R4 dir up again", dir_o, 0);

        // down
        wr(0, 16'hC009);
        wait_zero();
        step(1);
        chk("R3 reload period after zero", count_o, 3);
        chk("R3 period strobe", period_o, 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 100;
            clk_en = ($urandom % 10) != 0;
            if (r < 3) begin
                logic [15:0] d;
                d = '0;
                d[15:14] = 2'($urandom);
                d[1:0]   = 2'($urandom);
                d[3]     = 1'($urandom);
                d[12:10] = 3'($urandom % 2);
                d[9:7]   = 3'($urandom % 3);
                wr(0, d);
            end else if (r < 6) begin
                wr(1, 16'($urandom % 12));
            end else begin
                step(1);
            end
        end
        clk_en = 1;
        step(2);
        summary();
    end
endmodule